// File: doc/BRIEF.md
# Interrupt Event Assignment Table

This block holds one routing entry for every interrupt source. An entry names the event queue that should receive the source's events and the data word to post there. The table is addressed directly by the interrupt number, with no base offset, over the whole configured range of `NUM_SRC` sources. Every entry is one 64-bit word. Bit positions below use ordinary little-endian numbering, where bit 63 is the most significant bit:

- bit 63: valid
- bits 59:56: queue block (4 bits)
- bits 55:32: queue index (24 bits)
- bit 31: mask
- bits 30:0: queue data (31 bits)

Bits 62:60 are carried along but have no meaning.

Software uses the configuration port. A request carries an operation code (`cfgOp`: 0 = read, 1 = write, 2 = set valid, 3 = clear valid), an index and, for a write, a word. One cycle after the request the port answers with an acknowledge pulse and a success flag.

Event sources use the trigger port. One cycle after a trigger the block answers in one of two ways. If the entry is valid and unmasked, it forwards a routed event carrying the entry's queue block, queue index and data. Otherwise it pulses a dropped-event output.

Storage powers up as all zeros. Each reset starts a masking sweep that visits one entry per clock and sets the mask flag of every valid entry. While the sweep runs, `busy` is high and all requests are ignored.

Top module: `evt_assign_table`

## Requirements
- R1: While `rstN` is low, `busy` is 1 and `cfgAck`, `evtValid` and `evtDrop` are 0. After release, `busy` stays high for exactly `NUM_SRC` clock cycles, then falls, and it does not rise again until the next reset.
- R2: The reset sweep sets the mask flag (bit 31) of every entry whose valid flag (bit 63) is 1. It leaves entries whose valid flag is 0 untouched. Before any write, every entry reads as zero.
- R3: A write with an in-range index replaces the whole 64-bit entry in one cycle. A read returns the full entry on `cfgRdata`, with `cfgAck`=1 and `cfgOk`=1, one cycle after the request. Indices 0 and `NUM_SRC-1` are both usable.
- R4: A configuration request whose index is `NUM_SRC` or above is acknowledged with `cfgOk`=0 and `cfgRdata`=0, and no entry changes. A trigger on such an index produces `evtDrop`.
- R5: Set-valid (op 2) turns on only bit 63 of the entry. Clear-valid (op 3) turns off only bit 63. Both report `cfgOk`=1 for an in-range index.
- R6: A trigger on an entry with bit 63 = 1 and bit 31 = 0 produces a one-cycle `evtValid` pulse one cycle later. The pulse carries `evtBlock` = bits 59:56, `evtQueue` = bits 55:32 and `evtData` = bits 30:0.
- R7: A trigger on a masked entry or an invalid entry produces a one-cycle `evtDrop` pulse and no `evtValid`. The two outputs are never high together.
- R8: When a write and a trigger to the same index arrive in the same cycle, the trigger is resolved against the entry's previous contents.
- R9: Requests presented while `busy` is 1 are ignored. No acknowledge, event or drop follows, and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; starts the masking sweep |
| busy | output | 1 | High while the reset sweep runs |
| cfgReq | input | 1 | Configuration request strobe |
| cfgOp | input | 2 | 0 read, 1 write, 2 set valid, 3 clear valid |
| cfgIdx | input | IDX_W | Entry index (interrupt number) |
| cfgWdata | input | 64 | Entry word for a write |
| cfgAck | output | 1 | One-cycle acknowledge of an accepted request |
| cfgOk | output | 1 | Index was in range (valid with cfgAck) |
| cfgRdata | output | 64 | Entry word for a successful read, else 0 |
| trigReq | input | 1 | Event trigger strobe |
| trigIdx | input | IDX_W | Source raising the event |
| evtValid | output | 1 | One-cycle routed event pulse |
| evtBlock | output | 4 | Destination queue block |
| evtQueue | output | 24 | Destination queue index |
| evtData | output | 31 | Data to post to the queue |
| evtDrop | output | 1 | One-cycle pulse for a dropped trigger |

## Verification
The bench focuses on the corner cases most likely to be wrong:

- Same-cycle write and trigger. A design that forwards new data would route the event with the word being written instead of the old one.
- The sweep's effect on invalid entries. A sweep that masks every entry would set bit 31 on entries that were never valid.
- Trigger filtering. A block that tests only the mask flag, or only the valid flag, would forward events it must drop.
- Out-of-range indices and the last in-range index. An off-by-one range check would either corrupt state or reject entry `NUM_SRC-1`.
- Requests during the sweep. A design that accepts them would write the table or pulse outputs while `busy` is high.

// File: rtl/evt_assign_pkg.sv
package evt_assign_pkg;

  // Entry field positions (bit 63 = most significant)
  localparam int VALID_B = 63;
  localparam int BLK_HI  = 59;
  localparam int BLK_LO  = 56;
  localparam int QIDX_HI = 55;
  localparam int QIDX_LO = 32;
  localparam int MASK_B  = 31;
  localparam int DATA_HI = 30;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SETV  = 2'd2,
    OP_CLRV  = 2'd3
  } cfgOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sweep;
    logic rd;
    logic wr;
    logic setV;
    logic clrV;
    logic cfgBad;
    logic trigHit;
    logic trigBad;
  } tblStb_t;

endpackage

// File: rtl/evt_assign_ctrl.sv
module evt_assign_ctrl
  import evt_assign_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int IDX_W   = 6,
  parameter int PTR_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgReq,
  input  logic [1:0]       cfgOp,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             trigReq,
  input  logic [IDX_W-1:0] trigIdx,
  output tblStb_t          stb,
  output logic [PTR_W-1:0] sweepPtr,
  output logic             busy
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SRC - 1);

  logic cfgInRange;
  logic trigInRange;

  // Masking sweep: one entry per clock after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b1;
      sweepPtr <= '0;
    end else if (busy) begin
      if (sweepPtr == LAST) begin
        busy <= 1'b0;
      end else begin
        sweepPtr <= sweepPtr + 1'b1;
      end
    end
  end

  always_comb begin
    cfgInRange  = 32'(cfgIdx) < NUM_SRC;
    trigInRange = 32'(trigIdx) < NUM_SRC;
    stb         = '0;
    stb.sweep   = busy;
    if (!busy) begin
      if (cfgReq) begin
        stb.cfgBad = !cfgInRange;
        unique case (cfgOp_e'(cfgOp))
          OP_READ:  stb.rd   = cfgInRange;
          OP_WRITE: stb.wr   = cfgInRange;
          OP_SETV:  stb.setV = cfgInRange;
          OP_CLRV:  stb.clrV = cfgInRange;
          default:  stb.rd   = 1'b0;
        endcase
      end
      if (trigReq) begin
        stb.trigHit = trigInRange;
        stb.trigBad = !trigInRange;
      end
    end
  end

endmodule

// File: rtl/evt_assign_dpath.sv
module evt_assign_dpath
  import evt_assign_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int IDX_W   = 6,
  parameter int PTR_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  tblStb_t          stb,
  input  logic [PTR_W-1:0] sweepPtr,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [63:0]      cfgWdata,
  input  logic [IDX_W-1:0] trigIdx,
  output logic             cfgAck,
  output logic             cfgOk,
  output logic [63:0]      cfgRdata,
  output logic             evtValid,
  output logic [3:0]       evtBlock,
  output logic [23:0]      evtQueue,
  output logic [30:0]      evtData,
  output logic             evtDrop
);

  logic [63:0] tbl [NUM_SRC] = '{default: '0};

  logic [PTR_W-1:0] cIdx;
  logic [PTR_W-1:0] tIdx;
  logic [63:0]      cWord;
  logic [63:0]      tWord;
  logic             tPass;

  always_comb begin
    cIdx  = cfgIdx[PTR_W-1:0];
    tIdx  = trigIdx[PTR_W-1:0];
    cWord = tbl[cIdx];
    tWord = tbl[tIdx];
    tPass = tWord[VALID_B] && !tWord[MASK_B];
  end

  // Table storage: no reset, powers up at zero
  always_ff @(posedge clk) begin
    if (stb.sweep && tbl[sweepPtr][VALID_B]) begin
      tbl[sweepPtr][MASK_B] <= 1'b1;
    end
    if (stb.wr) begin
      tbl[cIdx] <= cfgWdata;
    end
    if (stb.setV) begin
      tbl[cIdx][VALID_B] <= 1'b1;
    end
    if (stb.clrV) begin
      tbl[cIdx][VALID_B] <= 1'b0;
    end
  end

  // Registered responses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAck   <= 1'b0;
      cfgOk    <= 1'b0;
      cfgRdata <= '0;
      evtValid <= 1'b0;
      evtBlock <= '0;
      evtQueue <= '0;
      evtData  <= '0;
      evtDrop  <= 1'b0;
    end else begin
      cfgAck   <= stb.rd || stb.wr || stb.setV || stb.clrV || stb.cfgBad;
      cfgOk    <= stb.rd || stb.wr || stb.setV || stb.clrV;
      cfgRdata <= stb.rd ? cWord : '0;
      evtValid <= stb.trigHit && tPass;
      evtDrop  <= stb.trigBad || (stb.trigHit && !tPass);
      if (stb.trigHit && tPass) begin
        evtBlock <= tWord[BLK_HI:BLK_LO];
        evtQueue <= tWord[QIDX_HI:QIDX_LO];
        evtData  <= tWord[DATA_HI:0];
      end else begin
        evtBlock <= '0;
        evtQueue <= '0;
        evtData  <= '0;
      end
    end
  end

endmodule

// File: rtl/evt_assign_table.sv
module evt_assign_table
  import evt_assign_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  output logic             busy,
  input  logic             cfgReq,
  input  logic [1:0]       cfgOp,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [63:0]      cfgWdata,
  output logic             cfgAck,
  output logic             cfgOk,
  output logic [63:0]      cfgRdata,
  input  logic             trigReq,
  input  logic [IDX_W-1:0] trigIdx,
  output logic             evtValid,
  output logic [3:0]       evtBlock,
  output logic [23:0]      evtQueue,
  output logic [30:0]      evtData,
  output logic             evtDrop
);

  localparam int PTR_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  tblStb_t          stb;
  logic [PTR_W-1:0] sweepPtr;

  evt_assign_ctrl #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgReq(cfgReq), .cfgOp(cfgOp), .cfgIdx(cfgIdx),
    .trigReq(trigReq), .trigIdx(trigIdx), .stb(stb), .sweepPtr(sweepPtr),
    .busy(busy)
  );

  evt_assign_dpath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PTR_W(PTR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sweepPtr(sweepPtr), .cfgIdx(cfgIdx),
    .cfgWdata(cfgWdata), .trigIdx(trigIdx), .cfgAck(cfgAck), .cfgOk(cfgOk),
    .cfgRdata(cfgRdata), .evtValid(evtValid), .evtBlock(evtBlock),
    .evtQueue(evtQueue), .evtData(evtData), .evtDrop(evtDrop)
  );

endmodule

// File: rtl/evt_assign_table_chk.sv
module evt_assign_table_chk #(
  parameter int NUM_SRC = 40,
  parameter int IDX_W   = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             cfgReq,
  input logic [IDX_W-1:0] cfgIdx,
  input logic             cfgAck,
  input logic             cfgOk,
  input logic [63:0]      cfgRdata,
  input logic             trigReq,
  input logic             evtValid,
  input logic             evtDrop
);

  // R1
  busy_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !busy);

  // R9
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!cfgAck && !evtValid && !evtDrop));

  // R7
  valid_drop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evtValid && evtDrop));

  // R4
  ok_matches_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgAck |-> (cfgOk == (32'($past(cfgIdx)) < NUM_SRC)));

  // R4
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAck && !cfgOk) |-> (cfgRdata == 64'd0));

  // R6
  event_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid || evtDrop) |-> ($past(trigReq) && !$past(busy)));

  // R3
  ack_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgAck |-> $past(cfgReq));

endmodule

bind evt_assign_table evt_assign_table_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .cfgReq(cfgReq), .cfgIdx(cfgIdx),
  .cfgAck(cfgAck), .cfgOk(cfgOk), .cfgRdata(cfgRdata), .trigReq(trigReq),
  .evtValid(evtValid), .evtDrop(evtDrop)
);

// File: tb/evt_assign_table_tb.sv
module evt_assign_table_tb_top;

  localparam int NUM_SRC = 40;
  localparam int IDX_W   = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busy;
  logic             cfgReq = 1'b0;
  logic [1:0]       cfgOp = 2'd0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [63:0]      cfgWdata = '0;
  logic             cfgAck, cfgOk;
  logic [63:0]      cfgRdata;
  logic             trigReq = 1'b0;
  logic [IDX_W-1:0] trigIdx = '0;
  logic             evtValid, evtDrop;
  logic [3:0]       evtBlock;
  logic [23:0]      evtQueue;
  logic [30:0]      evtData;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int          due;
    bit          ack;
    bit          ok;
    logic [63:0] rdata;
    bit          ev;
    logic [3:0]  blk;
    logic [23:0] q;
    logic [30:0] dat;
    bit          drop;
    string       tag;
  } expItem_t;

  expItem_t    sb[$];
  logic [63:0] model [NUM_SRC];

  evt_assign_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rstN(rstN), .busy(busy), .cfgReq(cfgReq), .cfgOp(cfgOp),
    .cfgIdx(cfgIdx), .cfgWdata(cfgWdata), .cfgAck(cfgAck), .cfgOk(cfgOk),
    .cfgRdata(cfgRdata), .trigReq(trigReq), .trigIdx(trigIdx),
    .evtValid(evtValid), .evtBlock(evtBlock), .evtQueue(evtQueue),
    .evtData(evtData), .evtDrop(evtDrop)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] mk(bit v, logic [3:0] b, logic [23:0] q,
                                     bit m, logic [30:0] d);
    return {v, 3'b000, b, q, m, d};
  endfunction

  task automatic check(bit cond, string tag, string what, logic [63:0] act,
                       logic [63:0] exp);
    nTests++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: one request per call, expectation pushed to the scoreboard
  task automatic issue(bit doCfg, logic [1:0] op, int idx, logic [63:0] wd,
                       bit doTrig, int tIdx, string tag);
    expItem_t e;
    bit       cIn, tIn;
    @(negedge clk);
    cfgReq   = doCfg;
    cfgOp    = op;
    cfgIdx   = IDX_W'(idx);
    cfgWdata = wd;
    trigReq  = doTrig;
    trigIdx  = IDX_W'(tIdx);
    if (!busy) begin
      cIn      = idx < NUM_SRC;
      tIn      = tIdx < NUM_SRC;
      e        = '{due: cyc + 1, ack: doCfg, ok: doCfg && cIn, rdata: '0,
                   ev: 0, blk: '0, q: '0, dat: '0, drop: 0, tag: tag};
      if (doTrig) begin
        if (tIn && model[tIdx][63] && !model[tIdx][31]) begin
          e.ev  = 1;
          e.blk = model[tIdx][59:56];
          e.q   = model[tIdx][55:32];
          e.dat = model[tIdx][30:0];
        end else begin
          e.drop = 1;
        end
      end
      if (doCfg && cIn) begin
        case (op)
          2'd0: e.rdata = model[idx];
          2'd1: model[idx] = wd;
          2'd2: model[idx][63] = 1'b1;
          default: model[idx][63] = 1'b0;
        endcase
      end
      if (doCfg || doTrig) sb.push_back(e);
    end
    @(negedge clk);
    cfgReq  = 1'b0;
    trigReq = 1'b0;
  endtask

  // Monitor: pops and compares at the cycle each result is due
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        expItem_t e;
        e = sb.pop_front();
        check(cfgAck == e.ack && evtValid == e.ev && evtDrop == e.drop, e.tag,
              "ack/ev/drop", {61'd0, cfgAck, evtValid, evtDrop},
              {61'd0, e.ack, e.ev, e.drop});
        if (e.ack) check(cfgOk == e.ok && cfgRdata == e.rdata, e.tag,
                         "ok/rdata", {cfgOk, cfgRdata[62:0]}, {e.ok, e.rdata[62:0]});
        if (e.ack) check(cfgRdata[63] == e.rdata[63], e.tag, "rdata msb",
                         64'(cfgRdata[63]), 64'(e.rdata[63]));
        if (e.ev) check(evtBlock == e.blk && evtQueue == e.q && evtData == e.dat,
                        e.tag, "event fields", {5'd0, evtBlock, evtQueue, evtData},
                        {5'd0, e.blk, e.q, e.dat});
      end else if (cfgAck || evtValid || evtDrop) begin
        check(0, "R9", "unexpected output", {61'd0, cfgAck, evtValid, evtDrop}, 64'd0);
      end
    end
  end

  task automatic doReset(string tag);
    int t0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(busy === 1'b1 && !cfgAck && !evtValid && !evtDrop, "R1",
          "reset state", {60'd0, busy, cfgAck, evtValid, evtDrop}, 64'h8);
    for (int i = 0; i < NUM_SRC; i++) if (model[i][63]) model[i][31] = 1'b1;
    rstN = 1'b1;
    t0 = cyc;
    while (busy) @(negedge clk);
    check(cyc - t0 == NUM_SRC, tag, "busy duration", 64'(cyc - t0), 64'(NUM_SRC));
  endtask

  initial begin
    #(5ns * 100000);
    check(0, "WDOG", "watchdog expired", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_SRC; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b1 && !cfgAck && !evtValid && !evtDrop, "R1",
          "power-up reset state", {60'd0, busy, cfgAck, evtValid, evtDrop}, 64'h8);
    rstN = 1'b1;
    // R9: requests during the sweep are ignored
    issue(1, 2'd1, 3, mk(1, 4'h2, 24'h000333, 0, 31'h33), 1, 3, "R9");
    issue(1, 2'd2, 4, '0, 0, 0, "R9");
    while (busy) @(negedge clk);
    // R2/R9: untouched entries read as zero
    issue(1, 2'd0, 3, '0, 0, 0, "R9");
    issue(1, 2'd0, 4, '0, 0, 0, "R2");
    // R3: write/read at both ends of the range
    issue(1, 2'd1, 0, mk(1, 4'hA, 24'hABCDEF, 0, 31'h1234_5678), 0, 0, "R3");
    issue(1, 2'd0, 0, '0, 0, 0, "R3");
    issue(1, 2'd1, NUM_SRC - 1, mk(1, 4'h5, 24'h00FF00, 0, 31'h7FFF_FFFF), 0, 0, "R3");
    issue(1, 2'd0, NUM_SRC - 1, '0, 0, 0, "R3");
    // R6: forwarded events
    issue(0, 2'd0, 0, '0, 1, 0, "R6");
    issue(0, 2'd0, 0, '0, 1, NUM_SRC - 1, "R6");
    // R7: masked, invalid, out of range
    issue(1, 2'd1, 5, mk(1, 4'h1, 24'h5, 1, 31'h5), 0, 0, "R7");
    issue(0, 2'd0, 0, '0, 1, 5, "R7");
    issue(1, 2'd1, 6, mk(0, 4'h6, 24'h66, 0, 31'h66), 0, 0, "R7");
    issue(0, 2'd0, 0, '0, 1, 6, "R7");
    issue(0, 2'd0, 0, '0, 1, 45, "R4");
    // R4: out-of-range configuration
    issue(1, 2'd1, 45, mk(1, 4'hF, 24'hFFFFFF, 0, 31'h1), 0, 0, "R4");
    issue(1, 2'd0, 45, '0, 0, 0, "R4");
    issue(1, 2'd2, NUM_SRC, '0, 0, 0, "R4");
    issue(1, 2'd0, NUM_SRC - 1, '0, 0, 0, "R4");
    // R5: valid flag control
    issue(1, 2'd2, 6, '0, 0, 0, "R5");
    issue(1, 2'd0, 6, '0, 0, 0, "R5");
    issue(0, 2'd0, 0, '0, 1, 6, "R5");
    issue(1, 2'd3, 0, '0, 0, 0, "R5");
    issue(1, 2'd0, 0, '0, 0, 0, "R5");
    issue(0, 2'd0, 0, '0, 1, 0, "R5");
    // R8: same-cycle write and trigger sees old contents
    issue(1, 2'd1, NUM_SRC - 1, mk(1, 4'h9, 24'h123456, 0, 31'h0ABC_DEF0), 1, NUM_SRC - 1, "R8");
    issue(0, 2'd0, 0, '0, 1, NUM_SRC - 1, "R8");
    // R2: second reset masks valid entries only
    doReset("R1");
    issue(1, 2'd0, NUM_SRC - 1, '0, 0, 0, "R2");
    issue(1, 2'd0, 6, '0, 0, 0, "R2");
    issue(1, 2'd0, 0, '0, 0, 0, "R2");
    issue(0, 2'd0, 0, '0, 1, 6, "R2");
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R3", "scoreboard drained", 64'(sb.size()), 64'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule